// File: doc/BRIEF.md
# Per-Query Packet Aggregation Engine

This block folds incoming child packets into per-query aggregate buffers, so the main processor can stay asleep while a sensor node gathers results from its children. Bytes arrive from a radio interface one at a time. The first byte of a packet is a query identifier. The engine looks that identifier up among the configured queries and then runs the matching query's handler program. The program is a short list of combine operations. Each operation takes the next payload byte and merges it into the aggregate buffer by sum, maximum or minimum. The aggregate buffer has the same byte layout as the payload, so payload byte k lands on buffer byte k of that query.

For each query the engine counts completed child packets. It raises a one-cycle completion pulse when the count reaches the configured number of children, or when that query's wait timer expires. The count and the timer then restart for the next period. The buffer can be seeded through a load port and inspected through a read port. Sending the finished aggregate is left to other logic.

Top module: `pkt_agg_engine`

## Requirements
- R1: While reset is asserted, and right after it is released, `done` is all zero, every buffer byte reads 0, and all child counts and timers are zero.
- R2: A byte with `rx_valid` and `rx_sop` high is a header. It is compared against `cfg_qid` byte q for every q below `cfg_nq`, and the lowest matching q wins. The matched query's handler starts at program entry `cfg_hstart[q]`, and its first payload byte targets buffer address `cfg_base[q]`.
- R3: Program entry i is `prog[2i+1:2i]`: 0 = END, 1 = ADD (sum modulo 256), 2 = MAX (unsigned), 3 = MIN (unsigned). Each payload byte combines with the buffer byte at the pointer, after which both the pointer and the program entry advance by one. The result is visible on `rd_data` after the clock edge that takes the byte.
- R4: Once the handler reaches END, the remaining payload bytes of that packet are discarded, and no buffer byte changes.
- R5: A packet whose header matches no active query is consumed up to its `rx_last` byte. No buffer byte changes and no count changes.
- R6: A matched packet counts for its query on the byte that carries `rx_last`. A header carrying `rx_last` also counts. When the count reaches a nonzero `cfg_children`, `done[q]` is high for exactly the one cycle after that byte, and the count returns to zero. If `cfg_children` is 0, nothing is counted.
- R7: With a nonzero `cfg_timeout` T, each active query pulses `done[q]` every T+1 cycles when no completion occurs. A completion by count restarts that query's timer. If `cfg_timeout` is 0, the timer is disabled.
- R8: Queries at index `cfg_nq` or above never match a header and never assert `done`.
- R9: `ld_en` writes `ld_data` to buffer address `ld_addr` on the clock edge. If a combine writes in the same cycle, the load is dropped.
- R10: A header arriving in the middle of a packet abandons the unfinished packet, which is not counted, and starts the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Radio byte valid |
| rx_sop | input | 1 | Byte is a packet header (query ID) |
| rx_last | input | 1 | Byte ends the packet |
| rx_data | input | 8 | Radio byte |
| cfg_nq | input | 8 | Number of active queries |
| cfg_qid | input | NQ*8 | Query identifier per query |
| cfg_base | input | NQ*AW | Buffer base address per query |
| cfg_hstart | input | NQ*PW | Handler start entry per query |
| prog | input | 2*PD | Handler program, 2 bits per entry |
| cfg_children | input | CW | Expected child packets per period |
| cfg_timeout | input | TW | Wait limit in cycles (0 = off) |
| ld_en | input | 1 | Buffer load strobe |
| ld_addr | input | AW | Buffer load address |
| ld_data | input | 8 | Buffer load data |
| rd_addr | input | AW | Buffer read address |
| rd_data | output | 8 | Buffer byte at rd_addr |
| done | output | NQ | Per-query completion pulse |

## Verification
The bounds on counts and timers assume that `cfg_children` and `cfg_timeout` change only while every child count and timer is zero. They also assume the query table and program stay fixed while packets are in flight. The stimulus changes these settings only right after a completion, or while both features are disabled, and it drives the load port only between packets, except for the one test that deliberately collides a load with a combine. The check that the buffer holds its value takes for granted that nothing writes to it apart from radio bytes and loads. The bench therefore compares the buffer after every idle stretch and after every discarded byte.

// File: rtl/pkt_agg_engine.sv
module pkt_agg_engine #(
  parameter int NQ = 4,
  parameter int BD = 16,
  parameter int PD = 16,
  parameter int CW = 8,
  parameter int TW = 16,
  localparam int AW = $clog2(BD),
  localparam int PW = $clog2(PD),
  localparam int QI = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sop,
  input  logic              rx_last,
  input  logic [7:0]        rx_data,
  input  logic [7:0]        cfg_nq,
  input  logic [NQ*8-1:0]   cfg_qid,
  input  logic [NQ*AW-1:0]  cfg_base,
  input  logic [NQ*PW-1:0]  cfg_hstart,
  input  logic [2*PD-1:0]   prog,
  input  logic [CW-1:0]     cfg_children,
  input  logic [TW-1:0]     cfg_timeout,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_addr,
  input  logic [7:0]        ld_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data,
  output logic [NQ-1:0]     done
);

  typedef enum logic [1:0] {IDLE = 2'd0, RUN = 2'd1, DROP = 2'd2} st_t;

  st_t                    st;
  logic [PW-1:0]          pc;
  logic [AW-1:0]          ptr;
  logic [QI-1:0]          qsel, hq;
  logic                   hdr_hit;
  logic [7:0]             mem [BD];
  logic [7:0]             cur, nv;
  logic [1:0]             op;
  logic                   hs, pl, wr, fin;
  logic [QI-1:0]          fq;
  logic [NQ-1:0][CW-1:0]  cnt_v;
  logic [NQ-1:0][TW-1:0]  tmr_v;

  assign hs  = rx_valid && rx_sop;
  assign pl  = rx_valid && !rx_sop;
  assign op  = prog[{pc, 1'b0} +: 2];
  assign cur = mem[ptr];
  assign wr  = pl && st == RUN && op != 2'd0;
  assign fin = rx_last && ((hs && hdr_hit) || (pl && st == RUN));
  assign fq  = hs ? hq : qsel;
  assign rd_data = mem[rd_addr];

  always_comb begin
    hdr_hit = 1'b0;
    hq = '0;
    for (int q = NQ - 1; q >= 0; q--)
      if (q < int'(cfg_nq) && cfg_qid[q*8 +: 8] == rx_data) begin
        hdr_hit = 1'b1;
        hq = QI'(q);
      end
  end

  always_comb begin
    case (op)
      2'd1:    nv = rx_data + cur;
      2'd2:    nv = (rx_data > cur) ? rx_data : cur;
      2'd3:    nv = (rx_data < cur) ? rx_data : cur;
      default: nv = cur;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      pc   <= '0;
      ptr  <= '0;
      qsel <= '0;
    end else if (hs) begin
      qsel <= hq;
      ptr  <= cfg_base[hq*AW +: AW];
      pc   <= cfg_hstart[hq*PW +: PW];
      if (rx_last)      st <= IDLE;
      else if (hdr_hit) st <= RUN;
      else              st <= DROP;
    end else if (pl) begin
      if (wr) begin
        ptr <= ptr + 1'b1;
        pc  <= pc + 1'b1;
      end
      if (rx_last) st <= IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BD; i++) mem[i] <= 8'd0;
    end else if (wr) begin
      mem[ptr] <= nv;
    end else if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : gq
    logic [CW-1:0] c;
    logic [TW-1:0] t;
    logic          d, act, bump, full, tout;

    assign act  = g < int'(cfg_nq);
    assign bump = fin && fq == QI'(g) && cfg_children != '0;
    assign full = bump && (c + 1'b1) == cfg_children;
    assign tout = cfg_timeout != '0 && t == cfg_timeout;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c <= '0; t <= '0; d <= 1'b0;
      end else if (!act) begin
        c <= '0; t <= '0; d <= 1'b0;
      end else if (full || tout) begin
        c <= '0; t <= '0; d <= 1'b1;
      end else begin
        d <= 1'b0;
        c <= (cfg_children == '0) ? '0 : c + {{(CW-1){1'b0}}, bump};
        t <= (cfg_timeout == '0) ? '0 : t + 1'b1;
      end
    end

    assign done[g]  = d;
    assign cnt_v[g] = c;
    assign tmr_v[g] = t;
  end

endmodule

module pkt_agg_engine_chk #(
  parameter int NQ = 4,
  parameter int CW = 8,
  parameter int TW = 16,
  parameter int AW = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rx_valid,
  input logic                  rx_sop,
  input logic                  rx_last,
  input logic                  ld_en,
  input logic [AW-1:0]         rd_addr,
  input logic [7:0]            rd_data,
  input logic [NQ-1:0]         done,
  input logic [7:0]            cfg_nq,
  input logic [CW-1:0]         cfg_children,
  input logic [TW-1:0]         cfg_timeout,
  input logic [NQ-1:0][CW-1:0] cnt_v,
  input logic [NQ-1:0][TW-1:0] tmr_v,
  input logic [1:0]            st,
  input logic                  hdr_hit
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> done == '0);

  // R8
  inactive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done >> cfg_nq) == '0);

  // R4
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rd_addr) && !$past(rx_valid) && !$past(ld_en) |-> $stable(rd_data));

  // R5
  drop_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_sop && !hdr_hit && !rx_last |=> st == 2'd2);

  for (genvar g = 0; g < NQ; g++) begin : gb
    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_children != '0 |-> cnt_v[g] < cfg_children);
    // R7
    tmr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_timeout != '0 |-> tmr_v[g] <= cfg_timeout);
  end

endmodule

bind pkt_agg_engine pkt_agg_engine_chk #(.NQ(NQ), .CW(CW), .TW(TW), .AW(AW)) u_chk (.*);

// File: tb/sim_pkt_agg_engine.sv
module sim_pkt_agg_engine;
  localparam int NQ = 4, BD = 16, PD = 16, CW = 8, TW = 16, AW = 4, PW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_sop = 0, rx_last = 0;
  logic [7:0] rx_data = 0;
  logic [7:0] cfg_nq = 8'd4;
  logic [NQ*8-1:0] cfg_qid;
  logic [NQ*AW-1:0] cfg_base;
  logic [NQ*PW-1:0] cfg_hstart;
  logic [2*PD-1:0] prog;
  logic [CW-1:0] cfg_children = 0;
  logic [TW-1:0] cfg_timeout = 0;
  logic ld_en = 0;
  logic [AW-1:0] ld_addr = 0, rd_addr = 0;
  logic [7:0] ld_data = 0, rd_data;
  logic [NQ-1:0] done;

  logic [7:0] qid_b [4] = '{8'h10, 8'h22, 8'h35, 8'h4A};
  int base_b [4] = '{0, 4, 8, 12};
  int hst_b  [4] = '{0, 4, 8, 10};
  int plen   [4] = '{3, 2, 1, 2};
  logic [1:0] opt [4][3] = '{'{2'd1, 2'd2, 2'd3}, '{2'd3, 2'd1, 2'd0},
                             '{2'd2, 2'd0, 2'd0}, '{2'd1, 2'd1, 2'd0}};
  logic [7:0] m [16];
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  always_comb begin
    prog = '0;
    for (int q = 0; q < 4; q++) begin
      cfg_qid[q*8 +: 8] = qid_b[q];
      cfg_base[q*AW +: AW] = AW'(base_b[q]);
      cfg_hstart[q*PW +: PW] = PW'(hst_b[q]);
      for (int k = 0; k < plen[q]; k++) prog[2*(hst_b[q]+k) +: 2] = opt[q][k];
    end
  end

  pkt_agg_engine u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_last(rx_last),
    .rx_data(rx_data), .cfg_nq(cfg_nq), .cfg_qid(cfg_qid), .cfg_base(cfg_base),
    .cfg_hstart(cfg_hstart), .prog(prog), .cfg_children(cfg_children),
    .cfg_timeout(cfg_timeout), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done));

  function automatic logic [7:0] f(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b);
    case (op)
      2'd1: return a + b;
      2'd2: return (b > a) ? b : a;
      2'd3: return (b < a) ? b : a;
      default: return a;
    endcase
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic check_buf(input int a, input string r);
    rd_addr = AW'(a);
    #1;
    chk(rd_data == m[a], r, rd_data, m[a]);
  endtask

  task automatic ld(input int a, input logic [7:0] d);
    ld_en = 1; ld_addr = AW'(a); ld_data = d;
    @(negedge clk);
    ld_en = 0;
    m[a] = d;
  endtask

  task automatic put(input bit s, input bit l, input logic [7:0] d);
    rx_valid = 1; rx_sop = s; rx_last = l; rx_data = d;
    @(negedge clk);
    rx_valid = 0; rx_sop = 0; rx_last = 0;
  endtask

  task automatic send_pkt(input logic [7:0] id, input int n, input logic [7:0] p [5]);
    int q = -1;
    for (int i = 0; i < int'(cfg_nq); i++) if (q < 0 && qid_b[i] == id) q = i;
    put(1'b1, n == 0, id);
    for (int k = 0; k < n; k++) begin
      put(1'b0, k == n - 1, p[k]);
      if (q >= 0 && k < plen[q])
        m[base_b[q]+k] = f(opt[q][k], m[base_b[q]+k], p[k]);
    end
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m[i] = 8'd0;
    repeat (3) @(negedge clk);
    chk(done == '0, "R1 done in reset", done, 0);
    rst_n = 1;
    @(negedge clk);
    chk(done == '0, "R1 done after reset", done, 0);
    for (int i = 0; i < 16; i++) check_buf(i, "R1 buffer clear");

    // R3 sweep of ADD/MAX/MIN on query 0
    for (int ia = 0; ia < 16; ia++)
      for (int ib = 0; ib < 18; ib++) begin
        logic [7:0] a, b;
        a = 8'(ia * 17); b = 8'(ib * 15);
        ld(0, a); ld(1, a); ld(2, a);
        send_pkt(8'h10, 3, '{b, b, b, 8'd0, 8'd0});
        rd_addr = 0; #1; chk(rd_data == 8'(a + b), "R3 add", rd_data, 8'(a + b));
        rd_addr = 1; #1; chk(rd_data == ((a > b) ? a : b), "R3 max", rd_data, (a > b) ? a : b);
        rd_addr = 2; #1; chk(rd_data == ((a < b) ? a : b), "R3 min", rd_data, (a < b) ? a : b);
      end

    // R2 base/handler of query 1 and lowest index wins
    ld(4, 8'h80); ld(5, 8'h10); ld(8, 8'h33);
    qid_b[2] = 8'h22;
    send_pkt(8'h22, 2, '{8'h40, 8'h05, 8'd0, 8'd0, 8'd0});
    check_buf(4, "R2 q1 base min"); check_buf(5, "R2 q1 add");
    check_buf(8, "R2 duplicate id lower wins");
    qid_b[2] = 8'h35;

    // R4 extra bytes after END
    ld(3, 8'h77);
    send_pkt(8'h10, 5, '{8'h01, 8'h02, 8'h03, 8'h99, 8'hAA});
    for (int i = 0; i < 6; i++) check_buf(i, "R4 after END");

    // R5 unknown id
    cfg_children = 1;
    send_pkt(8'h99, 3, '{8'h11, 8'h22, 8'h33, 8'd0, 8'd0});
    chk(done == '0, "R5 no count", done, 0);
    for (int i = 0; i < 16; i++) check_buf(i, "R5 buffer untouched");

    // R8 inactive query
    cfg_nq = 2;
    send_pkt(8'h4A, 2, '{8'h05, 8'h06, 8'd0, 8'd0, 8'd0});
    chk(done == '0, "R8 inactive no done", done, 0);
    check_buf(12, "R8 inactive buf"); check_buf(13, "R8 inactive buf");
    cfg_children = 0;
    cfg_timeout = 3;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      chk(done == ((k % 4 == 0) ? 4'b0011 : 4'b0000), "R8 timeout active only", done,
          (k % 4 == 0) ? 3 : 0);
    end
    cfg_timeout = 0;
    cfg_nq = 4;
    @(negedge clk);

    // R6 completion by count
    cfg_children = 3;
    for (int p = 1; p <= 3; p++) begin
      send_pkt(8'h22, 2, '{8'(p), 8'(p), 8'd0, 8'd0, 8'd0});
      chk(done == ((p == 3) ? 4'b0010 : 4'b0000), "R6 count done", done, (p == 3) ? 2 : 0);
    end
    @(negedge clk);
    chk(done == '0, "R6 single pulse", done, 0);
    check_buf(4, "R6 buf"); check_buf(5, "R6 buf");
    cfg_children = 0;

    // R10 header mid-packet
    cfg_children = 1;
    put(1'b1, 1'b0, 8'h10);
    put(1'b0, 1'b0, 8'h05);
    m[0] = m[0] + 8'h05;
    chk(done == '0, "R10 no done mid", done, 0);
    send_pkt(8'h4A, 2, '{8'h03, 8'h04, 8'd0, 8'd0, 8'd0});
    chk(done == 4'b1000, "R10 only new packet counted", done, 8);
    check_buf(0, "R10 abandoned bytes kept"); check_buf(12, "R10 new pkt");
    check_buf(13, "R10 new pkt");

    // R9 load priority
    ld(7, 8'h5C);
    check_buf(7, "R9 load");
    put(1'b1, 1'b0, 8'h4A);
    rx_valid = 1; rx_data = 8'h21; ld_en = 1; ld_addr = 12; ld_data = 8'h40;
    @(negedge clk);
    rx_valid = 0; ld_en = 0;
    m[12] = m[12] + 8'h21;
    put(1'b0, 1'b1, 8'h02);
    m[13] = m[13] + 8'h02;
    check_buf(12, "R9 combine wins"); check_buf(13, "R9 next");

    // R7 timeout with count restart on q2
    @(negedge clk);
    cfg_timeout = 9;
    for (int k = 1; k <= 40; k++) begin
      logic [3:0] e;
      if (k == 3) begin
        rx_valid = 1; rx_sop = 1; rx_last = 1; rx_data = 8'h35;
      end
      @(negedge clk);
      rx_valid = 0; rx_sop = 0; rx_last = 0;
      e = (k % 10 == 0) ? 4'b1011 : 4'b0000;
      if (k >= 3 && (k - 3) % 10 == 0) e[2] = 1'b1;
      chk(done == e, "R7 timeout period", done, e);
    end
    cfg_timeout = 0;
    cfg_children = 0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) check_buf(i, "R4 final buffer");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule